// File: doc/BRIEF.md
# SMBus Host Status Register

This block holds the byte-wide status register of an SMBus host controller. The controller core reports its events as one-cycle pulses: a byte moved without the block buffer, an alert from the bus, a transfer cut short by a kill request, a collision on the bus, a device-side error, and a command that completed. Each pulse sets a sticky bit. The bit stays set until software writes a one to its position, and a zero leaves it untouched. The host-busy bit follows the core's busy signal directly. An in-use bit gives software a semaphore: the read that finds it clear takes ownership, and writing a one to it releases it.

The register can always be observed on `stat_rd`. A read access is a one-cycle `acc_rd` strobe. The value visible during that cycle is the value returned, and the in-use bit takes effect at the following edge. Two resets drive the block. The main-domain reset clears every bit. The platform reset clears every bit except the alert bit, which keeps alert evidence through a platform reset. `irq_req` is raised when interrupts are enabled and any of the completion, device error, bus error, failed or alert bits is set.

Top module: `smb_hstat`

## Requirements
- R1: After either reset with `core_busy` low, `stat_rd` reads 0x00 and `irq_req` is low.
- R2: A one-cycle event pulse sets its bit at the next clock edge, and the bit stays set after that. The positions are: completion bit 1, device error bit 2, bus error bit 3, failed bit 4, alert bit 5, byte done bit 7.
- R3: A write with `acc_wr` high clears every sticky bit whose position in `acc_wdata` holds a one. Bit positions written with zero are unaffected.
- R4: If an event pulse and a write-one-to-clear reach the same bit in the same cycle, the bit ends up set.
- R5: The byte-done bit is set by `ev_byte` only while `blkbuf_on` is low. A pulse while `blkbuf_on` is high leaves it clear.
- R6: Bit 6 (in-use) reads 0 on the first read after reset and 1 on every later read. Writing a one to bit 6 releases it so that the next read returns 0 again, and writing zero there does not release it. A read and a release in the same cycle leave the bit set.
- R7: The platform reset clears every bit except alert (bit 5). The main reset clears all bits, alert included.
- R8: Bit 0 always equals `core_busy`, and writes have no effect on it.
- R9: `irq_req` equals `irq_on` ANDed with the OR of bits 1 through 5. Byte done, in-use and busy never raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| main_rst_n | input | 1 | Main power-domain reset, asynchronous, active low; clears all bits |
| plat_rst_n | input | 1 | Platform reset, asynchronous, active low; spares the alert bit |
| acc_rd | input | 1 | One-cycle read access strobe |
| acc_wr | input | 1 | One-cycle write access strobe |
| acc_wdata | input | 8 | Write data; a one clears that bit |
| stat_rd | output | 8 | Current register value |
| ev_byte | input | 1 | Byte received or sent pulse |
| blkbuf_on | input | 1 | High while the block buffer is in use |
| ev_alert | input | 1 | Bus alert pulse |
| ev_killed | input | 1 | Transaction terminated by kill pulse |
| ev_collide | input | 1 | Bus collision pulse |
| ev_deverr | input | 1 | Device error pulse |
| ev_cmd_ok | input | 1 | Command completed pulse |
| core_busy | input | 1 | Command executing in the core |
| irq_on | input | 1 | Interrupt enable |
| irq_req | output | 1 | Interrupt request |

## Verification
A wrong sticky bit shows on `stat_rd` one edge after the pulse or write that should have moved it. If that bit is among bits 1 through 5, `irq_req` shows the error in the same cycle. A semaphore fault shows on the next read: two callers both see zero, or no caller ever does. A reset-domain mix-up appears right after the platform reset is released, as a missing or surviving alert bit. The sweep sends each event alone, each event against a simultaneous clear, and each write mask, so a fault in any single bit position shows within two cycles.

// File: rtl/smb_hstat_pkg.sv
package smb_hstat_pkg;
    localparam int unsigned REG_W   = 8;
    localparam int unsigned N_CORE  = 5;   // sticky bits in the platform reset domain
    localparam int unsigned P_BUSY  = 0;
    localparam int unsigned P_OK    = 1;
    localparam int unsigned P_DEV   = 2;
    localparam int unsigned P_COLL  = 3;
    localparam int unsigned P_KILL  = 4;
    localparam int unsigned P_ALERT = 5;
    localparam int unsigned P_INUSE = 6;
    localparam int unsigned P_BYTE  = 7;

    typedef struct packed {
        logic byte_done;
        logic in_use;
        logic alert;
        logic killed;
        logic collide;
        logic dev_err;
        logic cmd_ok;
        logic busy;
    } stat_view_t;
endpackage

// File: rtl/smb_hstat_sticky.sv
module smb_hstat_sticky #(
    parameter int unsigned W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q_o
);
    typedef struct packed {
        logic [W-1:0] bits;
    } sticky_t;

    sticky_t     st_d, st_q;
    logic [W-1:0] nxt;

    // event has priority over a simultaneous clear
    for (genvar i = 0; i < W; i++) begin : g_bit
        assign nxt[i] = set_i[i] | (st_q.bits[i] & ~clr_i[i]);
    end

    always_comb begin
        st_d      = st_q;
        st_d.bits = nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.bits;
endmodule

// File: rtl/smb_hstat_sem.sv
module smb_hstat_sem (
    input  logic clk,
    input  logic rst_n,
    input  logic take_i,
    input  logic give_i,
    output logic held_o
);
    typedef struct packed {
        logic held;
    } sem_t;

    sem_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (give_i) st_d.held = 1'b0;
        if (take_i) st_d.held = 1'b1;   // a read in the same cycle keeps ownership taken
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign held_o = st_q.held;
endmodule

// File: rtl/smb_hstat.sv
module smb_hstat
    import smb_hstat_pkg::*;
(
    input  logic             clk,
    input  logic             main_rst_n,
    input  logic             plat_rst_n,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic [REG_W-1:0] acc_wdata,
    output logic [REG_W-1:0] stat_rd,
    input  logic             ev_byte,
    input  logic             blkbuf_on,
    input  logic             ev_alert,
    input  logic             ev_killed,
    input  logic             ev_collide,
    input  logic             ev_deverr,
    input  logic             ev_cmd_ok,
    input  logic             core_busy,
    input  logic             irq_on,
    output logic             irq_req
);
    logic              core_rst_n;
    logic [N_CORE-1:0] core_set, core_clr, core_q;
    logic              alert_q, in_use_q;
    logic [REG_W-1:0]  wmask;
    stat_view_t        view;

    assign core_rst_n = main_rst_n & plat_rst_n;
    assign wmask      = acc_wr ? acc_wdata : '0;

    // core vector order: {byte_done, killed, collide, dev_err, cmd_ok}
    assign core_set = {ev_byte & ~blkbuf_on, ev_killed, ev_collide, ev_deverr, ev_cmd_ok};
    assign core_clr = {wmask[P_BYTE], wmask[P_KILL], wmask[P_COLL], wmask[P_DEV], wmask[P_OK]};

    smb_hstat_sticky #(.W(N_CORE)) u_core (
        .clk   (clk),
        .rst_n (core_rst_n),
        .set_i (core_set),
        .clr_i (core_clr),
        .q_o   (core_q)
    );

    smb_hstat_sticky #(.W(1)) u_alert (
        .clk   (clk),
        .rst_n (main_rst_n),
        .set_i (ev_alert),
        .clr_i (wmask[P_ALERT]),
        .q_o   (alert_q)
    );

    smb_hstat_sem u_sem (
        .clk    (clk),
        .rst_n  (core_rst_n),
        .take_i (acc_rd),
        .give_i (wmask[P_INUSE]),
        .held_o (in_use_q)
    );

    always_comb begin
        view           = '0;
        view.byte_done = core_q[4];
        view.in_use    = in_use_q;
        view.alert     = alert_q;
        view.killed    = core_q[3];
        view.collide   = core_q[2];
        view.dev_err   = core_q[1];
        view.cmd_ok    = core_q[0];
        view.busy      = core_busy;
        stat_rd        = view;
        irq_req        = irq_on & (view.cmd_ok | view.dev_err | view.collide
                                   | view.killed | view.alert);
    end
endmodule

// File: rtl/smb_hstat_chk.sv
module smb_hstat_chk (
    input logic       clk,
    input logic       main_rst_n,
    input logic       plat_rst_n,
    input logic       acc_rd,
    input logic       acc_wr,
    input logic [7:0] acc_wdata,
    input logic [7:0] stat_rd,
    input logic       ev_byte,
    input logic       blkbuf_on,
    input logic       ev_cmd_ok,
    input logic       ev_collide,
    input logic       irq_on,
    input logic       irq_req
);
    assert_set_R2: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        ev_cmd_ok |=> stat_rd[1]);

    assert_hold_R2: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        (stat_rd[3] && !(acc_wr && acc_wdata[3])) |=> stat_rd[3]);

    assert_clear_R3: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        (acc_wr && acc_wdata[1] && !ev_cmd_ok) |=> !stat_rd[1]);

    assert_set_wins_R4: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        (ev_collide && acc_wr && acc_wdata[3]) |=> stat_rd[3]);

    assert_buf_gate_R5: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        (ev_byte && blkbuf_on && !stat_rd[7]) |=> !stat_rd[7]);

    assert_take_R6: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        acc_rd |=> stat_rd[6]);

    assert_irq_src_R9: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        irq_req |-> (irq_on && (|stat_rd[5:1])));

    assert_irq_raise_R9: assert property (@(posedge clk) disable iff (!main_rst_n || !plat_rst_n)
        (irq_on && (|stat_rd[5:1])) |-> irq_req);
endmodule

bind smb_hstat smb_hstat_chk u_chk (
    .clk        (clk),
    .main_rst_n (main_rst_n),
    .plat_rst_n (plat_rst_n),
    .acc_rd     (acc_rd),
    .acc_wr     (acc_wr),
    .acc_wdata  (acc_wdata),
    .stat_rd    (stat_rd),
    .ev_byte    (ev_byte),
    .blkbuf_on  (blkbuf_on),
    .ev_cmd_ok  (ev_cmd_ok),
    .ev_collide (ev_collide),
    .irq_on     (irq_on),
    .irq_req    (irq_req)
);

// File: tb/smb_hstat_tb.sv
module smb_hstat_tb;
    logic       clk = 1'b0;
    logic       main_rst_n = 1'b0, plat_rst_n = 1'b0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0;
    logic [7:0] acc_wdata = 8'h00;
    logic [7:0] stat_rd;
    logic [5:0] ev = 6'b0;   // 0 ok, 1 dev, 2 coll, 3 kill, 4 alert, 5 byte
    logic       blkbuf_on = 1'b0, core_busy = 1'b0, irq_on = 1'b0;
    logic       irq_req;
    int         errs = 0, checks = 0;

    always #5 clk = ~clk;

    smb_hstat u_dut (
        .clk        (clk),
        .main_rst_n (main_rst_n),
        .plat_rst_n (plat_rst_n),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .acc_wdata  (acc_wdata),
        .stat_rd    (stat_rd),
        .ev_byte    (ev[5]),
        .blkbuf_on  (blkbuf_on),
        .ev_alert   (ev[4]),
        .ev_killed  (ev[3]),
        .ev_collide (ev[2]),
        .ev_deverr  (ev[1]),
        .ev_cmd_ok  (ev[0]),
        .core_busy  (core_busy),
        .irq_on     (irq_on),
        .irq_req    (irq_req)
    );

    function automatic logic [7:0] pos_of(int k);
        return (k < 5) ? (8'h01 << (k + 1)) : 8'h80;
    endfunction

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic pulse(int k);
        ev[k] = 1'b1;
        @(negedge clk);
        ev[k] = 1'b0;
        #1;
    endtask

    task automatic wr(logic [7:0] d);
        acc_wr = 1'b1; acc_wdata = d;
        @(negedge clk);
        acc_wr = 1'b0; acc_wdata = 8'h00;
        #1;
    endtask

    task automatic rd(output logic [7:0] v);
        acc_rd = 1'b1;
        #1 v = stat_rd;
        @(negedge clk);
        acc_rd = 1'b0;
        #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        main_rst_n = 1'b1; plat_rst_n = 1'b1;
        #1;
        chk("R1 reset value", stat_rd, 8'h00);
        chk("R1 reset irq", {7'b0, irq_req}, 8'h00);

        core_busy = 1'b1; #1;
        chk("R8 busy mirror", stat_rd, 8'h01);
        wr(8'hBF);
        chk("R8 write ignored", stat_rd, 8'h01);
        core_busy = 1'b0; #1;
        chk("R8 busy low", stat_rd, 8'h00);

        // sweep: every event, with interrupts off and on
        for (int k = 0; k < 6; k++) begin
            for (int en = 0; en < 2; en++) begin
                logic [7:0] e;
                e = pos_of(k);
                pulse(k);
                chk("R2 event sets bit", stat_rd, e);
                @(negedge clk); #1;
                chk("R2 bit sticky", stat_rd, e);
                irq_on = en[0]; #1;
                chk("R9 irq", {7'b0, irq_req}, {7'b0, (en == 1) && (k < 5)});
                irq_on = 1'b0;
                wr(8'h00);
                chk("R3 write zero", stat_rd, e);
                wr(~e & 8'hBF);
                chk("R3 other bits", stat_rd, e);
                wr(e);
                chk("R3 w1c", stat_rd, 8'h00);
            end
        end

        // set wins against a clear in the same cycle
        for (int k = 0; k < 6; k++) begin
            ev[k] = 1'b1; acc_wr = 1'b1; acc_wdata = pos_of(k);
            @(negedge clk);
            ev[k] = 1'b0; acc_wr = 1'b0; acc_wdata = 8'h00;
            #1;
            chk("R4 set beats clear", stat_rd, pos_of(k));
            wr(pos_of(k));
        end

        // block buffer gating
        blkbuf_on = 1'b1;
        pulse(5);
        chk("R5 gated by buffer", stat_rd, 8'h00);
        blkbuf_on = 1'b0;
        pulse(5);
        chk("R5 byte done", stat_rd, 8'h80);
        irq_on = 1'b1; #1;
        chk("R9 byte done no irq", {7'b0, irq_req}, 8'h00);

        // all together
        ev = 6'h3F;
        @(negedge clk);
        ev = 6'h00; #1;
        chk("R2 all events", stat_rd, 8'hBE);
        chk("R9 irq all", {7'b0, irq_req}, 8'h01);
        wr(8'h3E);
        chk("R3 partial clear", stat_rd, 8'h80);
        chk("R9 irq drops", {7'b0, irq_req}, 8'h00);
        wr(8'h80);

        // semaphore
        rd(v);
        chk("R6 first read", v, 8'h00);
        chk("R6 held", stat_rd, 8'h40);
        chk("R9 in-use no irq", {7'b0, irq_req}, 8'h00);
        irq_on = 1'b0;
        rd(v);
        chk("R6 second read", v, 8'h40);
        wr(8'h00);
        chk("R6 zero no release", stat_rd, 8'h40);
        wr(8'h40);
        chk("R6 release", stat_rd, 8'h00);
        rd(v);
        chk("R6 read after release", v, 8'h00);
        acc_rd = 1'b1; acc_wr = 1'b1; acc_wdata = 8'h40;
        @(negedge clk);
        acc_rd = 1'b0; acc_wr = 1'b0; acc_wdata = 8'h00; #1;
        chk("R6 read beats release", stat_rd, 8'h40);

        // reset domains
        pulse(4);
        pulse(3);
        chk("R7 before reset", stat_rd, 8'h70);
        plat_rst_n = 1'b0;
        @(negedge clk);
        plat_rst_n = 1'b1; #1;
        chk("R7 platform reset keeps alert", stat_rd, 8'h20);
        main_rst_n = 1'b0;
        @(negedge clk);
        main_rst_n = 1'b1; #1;
        chk("R7 main reset clears alert", stat_rd, 8'h00);
        chk("R1 after main reset", {7'b0, irq_req}, 8'h00);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule